// File: doc/BRIEF.md
# Dual-Interrupt 32-Line GPIO Bank

This block is a 32-line general-purpose I/O bank sitting on a simple memory-mapped register bus with byte lanes. Each line can be made an output by clearing its direction bit, in which case the stored output data drives the pin. Lines left as inputs feed four detectors: rising edge, falling edge, level high and level low. Any detected event sets the line's bit in the status registers of both interrupt banks at once. Each bank has its own enable register and its own interrupt output.

Status bits are write-one-to-clear. After a status clear, the level conditions are evaluated again, so an input that is still at an armed level sets its bit again. The same happens after a write to the direction register or to either level register. Enables, wakeup enables and the output data each have clear and set alias addresses, so software can change single bits without a read-modify-write. A one-cycle wakeup pulse is raised only when the configuration allows wakeup, selects a non-zero idle mode, and the event hits a line whose wakeup enable is set.

Byte and half-word writes merge the written lanes into ordinary registers. Writes to status and alias addresses act only on the written lanes. The debounce registers are stored and read back but have no effect on timing.

Top module: `gpio_dual_irq_bank`

## Requirements
- R1: Reads at offset 0x00 return 0x18 and at 0x14 return 0x01. Writes to these offsets change nothing. Unmapped offsets read 0. The low two address bits are ignored.
- R2: The configuration register at 0x10 keeps only the bits of mask 0x1D. A write whose merged value has bit 1 set returns every other register to its reset value, and the configuration takes the masked written value.
- R3: After reset, the direction register (0x34) reads all ones and `pin_drive` is 0. The control register (0x30) reads 2. Status, enable, wakeup enable, output data, detect and debounce registers read 0. `irq_o` and `wake_o` are low.
- R4: On a line whose direction bit is 1, a rising edge (with rise-detect 0x48 set) or a falling edge (with fall-detect 0x4C set) sets the line's bit in both status registers (0x18, 0x28). The bit is readable two clocks after the pin changes. Lines with direction bit 0 produce no events.
- R5: On an input line, a transition that lands at high with level-high (0x44) set, or at low with level-low (0x40) set, sets the line's bit in both status registers.
- R6: Writing ones to status register n (0x18 + 0x10*n) clears those bits. One cycle later, bank n sets again every input line whose armed level condition still holds.
- R7: A write to 0x34, 0x40 or 0x44 re-evaluates the level conditions for both banks one cycle later, using the new register values.
- R8: `irq_o[n]` is high exactly when status n AND enable n (0x1C + 0x10*n) is non-zero.
- R9: For bank n, the enable register is written at 0x1C + 0x10*n, cleared by ones at 0x60 + 0x10*n and set by ones at 0x64 + 0x10*n. All three addresses read back the enable value.
- R10: Output data is written at 0x3C, cleared by ones at 0x90 and set by ones at 0x94, and all three read it back. `pin_out` carries the output data, and `pin_drive` is the inverse of the direction register.
- R11: `wake_o` pulses for one cycle after an event only if configuration bit 2 is 1, bits [4:3] are non-zero, and the event line is set in the wakeup-enable register. That register is written at 0x20, cleared by ones at 0x80 and set by ones at 0x84.
- R12: Byte-lane writes merge the lanes into ordinary registers. At status and alias addresses, the unwritten lanes count as zero.
- R13: When a status clear and an event hit the same bit in the same cycle, the bit ends up set.
- R14: The control register stores 3 bits, debounce-enable (0x50) stores 32 bits and debounce-time (0x54) stores 8 bits. Offset 0x38 reads the synchronized pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Read data, combinational during a read |
| pin_in | input | 32 | Pin levels |
| pin_out | output | 32 | Output data for the pins |
| pin_drive | output | 32 | Per-line driver enable (1 = output) |
| irq_o | output | 2 | Interrupt line per bank |
| wake_o | output | 1 | One-cycle wakeup request |

## Verification
The hardest case to reach from the ports is a status clear arriving in the same cycle that a pin edge is being recorded. The pin is sampled through two registers, so the bench changes it one cycle ahead of the status write. This aligns the edge at the status register with the write strobe. Level re-evaluation is reached by holding a pin at an armed level while the line is an output, and then turning it into an input with a direction write. The bench also clears status while the level is still present. Wakeup gating is stepped through each configuration combination with the same edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int LANES  = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // register offsets (software-visible map)
    localparam addr_t A_IDENT    = 8'h00;
    localparam addr_t A_CFG      = 8'h10;
    localparam addr_t A_DONE     = 8'h14;
    localparam addr_t A_WAKE_EN  = 8'h20;
    localparam addr_t A_CTL      = 8'h30;
    localparam addr_t A_DIR      = 8'h34;
    localparam addr_t A_PIN_IN   = 8'h38;
    localparam addr_t A_DOUT     = 8'h3C;
    localparam addr_t A_LVL_LO   = 8'h40;
    localparam addr_t A_LVL_HI   = 8'h44;
    localparam addr_t A_RISE     = 8'h48;
    localparam addr_t A_FALL     = 8'h4C;
    localparam addr_t A_DB_EN    = 8'h50;
    localparam addr_t A_DB_TIME  = 8'h54;
    localparam addr_t A_WAKE_CLR = 8'h80;
    localparam addr_t A_WAKE_SET = 8'h84;
    localparam addr_t A_DOUT_CLR = 8'h90;
    localparam addr_t A_DOUT_SET = 8'h94;

    // per-bank registers: base + bank * stride
    localparam addr_t A_STAT_BASE   = 8'h18;
    localparam addr_t A_EN_BASE     = 8'h1C;
    localparam addr_t A_ENCLR_BASE  = 8'h60;
    localparam addr_t A_ENSET_BASE  = 8'h64;
    localparam addr_t A_BANK_STRIDE = 8'h10;

    localparam word_t IDENT_VALUE = 32'h0000_0018;
    localparam word_t DONE_VALUE  = 32'h0000_0001;

    localparam logic [7:0] CFG_KEEP     = 8'h1D;
    localparam int         CFG_SRST_BIT = 1;
    localparam int         CFG_WAKE_BIT = 2;
    localparam int         CFG_IDLE_LO  = 3;
    localparam int         CTL_W        = 3;
    localparam logic [CTL_W-1:0] CTL_INIT = 3'd2;
    localparam int         DBT_W        = 8;

    typedef struct packed {
        word_t rise;
        word_t fall;
        word_t lvl_lo;
        word_t lvl_hi;
    } detect_cfg_t;

    typedef struct packed {
        logic wr_stat;
        logic wr_en;
        logic wr_en_clr;
        logic wr_en_set;
    } bank_wr_t;

    function automatic word_t lane_mask(input logic [LANES-1:0] be);
        word_t m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic addr_t bank_addr(input addr_t base, input int bank);
        return base + addr_t'(bank) * A_BANK_STRIDE;
    endfunction
endpackage

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  word_t       pin_i,
    input  word_t       dir_i,
    input  detect_cfg_t det_i,
    output word_t       sampled_o,
    output word_t       event_o,
    output word_t       level_o
);
    word_t sync_q, prev_q;
    word_t rising, falling, holding;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            sync_q <= pin_i;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        rising  = sync_q & ~prev_q;
        falling = ~sync_q & prev_q;
        holding = (sync_q & det_i.lvl_hi) | (~sync_q & det_i.lvl_lo);
        // R4, R5: only input lines (direction bit 1) raise events
        event_o = dir_i & ((rising & det_i.rise) | (falling & det_i.fall) |
                           ((rising | falling) & holding));
        level_o = dir_i & holding;
    end

    assign sampled_o = sync_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bank_wr_t wr_i,
    input  word_t    merged_i,
    input  word_t    lanes_i,
    input  word_t    event_i,
    input  word_t    reeval_i,
    output word_t    status_o,
    output word_t    enable_o,
    output logic     irq_o
);
    word_t status_q, enable_q, clr_v;

    assign clr_v = wr_i.wr_stat ? lanes_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            // R13: a set from an event or re-evaluation wins over the clear
            status_q <= (status_q & ~clr_v) | event_i | reeval_i;
            if (wr_i.wr_en)
                enable_q <= merged_i;
            else if (wr_i.wr_en_clr)
                enable_q <= enable_q & ~lanes_i;
            else if (wr_i.wr_en_set)
                enable_q <= enable_q | lanes_i;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign irq_o    = |(status_q & enable_q);   // R8
endmodule

// File: rtl/gpio_dual_irq_bank.sv
module gpio_dual_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_drive,
    output logic [NUM_IRQ-1:0] irq_o,
    output logic              wake_o
);
    addr_t       a;
    logic        wr_go, soft_rst, srst, wr_relevel;
    word_t       lm, lanes_v, rd_v, merged;
    logic [7:0]  cfg_q;
    logic [CTL_W-1:0] ctl_q;
    logic [DBT_W-1:0] db_time_q;
    word_t       dir_q, dout_q, wake_en_q, db_en_q;
    detect_cfg_t det_q;
    word_t       sampled_v, evt_v, level_v;
    logic [NUM_IRQ-1:0] pend_q;
    logic        wake_q;
    logic [NUM_IRQ-1:0][DATA_W-1:0] stat_v, en_v;
    bank_wr_t    bwr [NUM_IRQ];

    assign a       = {bus_addr[ADDR_W-1:2], 2'b00};   // R1: low bits ignored
    assign wr_go   = bus_sel & bus_wr;
    assign lm      = lane_mask(bus_be);
    assign lanes_v = bus_wdata & lm;                   // R12: alias lanes
    assign merged  = (rd_v & ~lm) | lanes_v;           // R12: merge lanes

    // R2: soft reset from the configuration register
    assign soft_rst   = wr_go && (a == A_CFG) && merged[CFG_SRST_BIT];
    assign srst       = rst | soft_rst;
    // R7: direction and level writes re-evaluate both banks
    assign wr_relevel = wr_go && ((a == A_DIR) || (a == A_LVL_LO) || (a == A_LVL_HI));

    always_comb begin
        rd_v = '0;
        case (a)
            A_IDENT:   rd_v = IDENT_VALUE;
            A_DONE:    rd_v = DONE_VALUE;
            A_CFG:     rd_v = word_t'(cfg_q);
            A_CTL:     rd_v = word_t'(ctl_q);
            A_DIR:     rd_v = dir_q;
            A_PIN_IN:  rd_v = sampled_v;
            A_LVL_LO:  rd_v = det_q.lvl_lo;
            A_LVL_HI:  rd_v = det_q.lvl_hi;
            A_RISE:    rd_v = det_q.rise;
            A_FALL:    rd_v = det_q.fall;
            A_DB_EN:   rd_v = db_en_q;
            A_DB_TIME: rd_v = word_t'(db_time_q);
            A_WAKE_EN, A_WAKE_CLR, A_WAKE_SET: rd_v = wake_en_q;
            A_DOUT, A_DOUT_CLR, A_DOUT_SET:    rd_v = dout_q;
            default:   rd_v = '0;
        endcase
        for (int b = 0; b < NUM_IRQ; b++) begin
            if (a == bank_addr(A_STAT_BASE, b))
                rd_v = stat_v[b];
            if ((a == bank_addr(A_EN_BASE, b)) || (a == bank_addr(A_ENCLR_BASE, b)) ||
                (a == bank_addr(A_ENSET_BASE, b)))
                rd_v = en_v[b];
        end
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? rd_v : '0;

    // configuration survives its own soft reset with the new value
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_go && (a == A_CFG))
            cfg_q <= merged[7:0] & CFG_KEEP;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            ctl_q     <= CTL_INIT;
            dir_q     <= '1;
            dout_q    <= '0;
            wake_en_q <= '0;
            det_q     <= '0;
            db_en_q   <= '0;
            db_time_q <= '0;
        end else if (wr_go) begin
            case (a)
                A_CTL:      ctl_q        <= merged[CTL_W-1:0];
                A_DIR:      dir_q        <= merged;
                A_DOUT:     dout_q       <= merged;
                A_DOUT_CLR: dout_q       <= dout_q & ~lanes_v;
                A_DOUT_SET: dout_q       <= dout_q | lanes_v;
                A_WAKE_EN:  wake_en_q    <= merged;
                A_WAKE_CLR: wake_en_q    <= wake_en_q & ~lanes_v;
                A_WAKE_SET: wake_en_q    <= wake_en_q | lanes_v;
                A_LVL_LO:   det_q.lvl_lo <= merged;
                A_LVL_HI:   det_q.lvl_hi <= merged;
                A_RISE:     det_q.rise   <= merged;
                A_FALL:     det_q.fall   <= merged;
                A_DB_EN:    db_en_q      <= merged;
                A_DB_TIME:  db_time_q    <= merged[DBT_W-1:0];
                default: ;
            endcase
        end
    end

    gpio_event_detect det_i (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (pin_in),
        .dir_i    (dir_q),
        .det_i    (det_q),
        .sampled_o(sampled_v),
        .event_o  (evt_v),
        .level_o  (level_v)
    );

    // R6, R7: re-evaluation is applied one cycle after the triggering write
    always_ff @(posedge clk) begin
        if (srst) begin
            pend_q <= '0;
            wake_q <= 1'b0;
        end else begin
            for (int b = 0; b < NUM_IRQ; b++)
                pend_q[b] <= bwr[b].wr_stat | wr_relevel;
            // R11: wakeup gating
            wake_q <= cfg_q[CFG_WAKE_BIT] && (cfg_q[CFG_IDLE_LO+1:CFG_IDLE_LO] != 2'b00) &&
                      (|(evt_v & wake_en_q));
        end
    end

    generate
        for (genvar gb = 0; gb < NUM_IRQ; gb++) begin : g_bank
            assign bwr[gb].wr_stat   = wr_go && (a == bank_addr(A_STAT_BASE, gb));
            assign bwr[gb].wr_en     = wr_go && (a == bank_addr(A_EN_BASE, gb));
            assign bwr[gb].wr_en_clr = wr_go && (a == bank_addr(A_ENCLR_BASE, gb));
            assign bwr[gb].wr_en_set = wr_go && (a == bank_addr(A_ENSET_BASE, gb));

            gpio_irq_bank bank_i (
                .clk     (clk),
                .rst     (srst),
                .wr_i    (bwr[gb]),
                .merged_i(merged),
                .lanes_i (lanes_v),
                .event_i (evt_v),
                .reeval_i(pend_q[gb] ? level_v : '0),
                .status_o(stat_v[gb]),
                .enable_o(en_v[gb]),
                .irq_o   (irq_o[gb])
            );
        end
    endgenerate

    assign pin_out   = dout_q;      // R10
    assign pin_drive = ~dir_q;
    assign wake_o    = wake_q;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          soft_rst,
    input logic                          bus_sel,
    input logic                          bus_wr,
    input addr_t                         bus_addr,
    input word_t                         bus_wdata,
    input logic [LANES-1:0]              bus_be,
    input word_t                         bus_rdata,
    input word_t                         pin_drive,
    input word_t                         evt_v,
    input logic [NUM_IRQ-1:0][DATA_W-1:0] stat_v,
    input logic [NUM_IRQ-1:0][DATA_W-1:0] en_v,
    input logic [NUM_IRQ-1:0]            irq_o,
    input logic                          wake_o,
    input logic [7:0]                    cfg_q
);
    p_ident_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && ({bus_addr[ADDR_W-1:2], 2'b00} == A_IDENT)) |-> (bus_rdata == IDENT_VALUE));

    p_reset_no_drive_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_drive == '0));

    p_event_both_banks_r4: assert property (@(posedge clk) disable iff (rst)
        ((|evt_v) && !soft_rst) |=>
        (((stat_v[0] & $past(evt_v)) == $past(evt_v)) &&
         ((stat_v[NUM_IRQ-1] & $past(evt_v)) == $past(evt_v))));

    p_dir_write_drive_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && ({bus_addr[ADDR_W-1:2], 2'b00} == A_DIR) && (bus_be == '1))
        |=> (pin_drive == ~$past(bus_wdata)));

    p_wake_gated_r11: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> ($past(cfg_q[CFG_WAKE_BIT]) && ($past(cfg_q[CFG_IDLE_LO+1:CFG_IDLE_LO]) != 2'b00)));

    generate
        for (genvar gb = 0; gb < NUM_IRQ; gb++) begin : g_irq_chk
            p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
                (en_v[gb] == '0) |-> !irq_o[gb]);
        end
    endgenerate
endmodule

bind gpio_dual_irq_bank gpio_bank_checker #(.NUM_IRQ(NUM_IRQ)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_be   (bus_be),
    .bus_rdata(bus_rdata),
    .pin_drive(pin_drive),
    .evt_v    (evt_v),
    .stat_v   (stat_v),
    .en_v     (en_v),
    .irq_o    (irq_o),
    .wake_o   (wake_o),
    .cfg_q    (cfg_q)
);

// File: tb/gpio_dual_irq_bank_tb.sv
`timescale 1ns/100ps
module gpio_dual_irq_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = '0;
    logic [31:0] pin_out, pin_drive;
    logic [1:0]  irq_o;
    logic        wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_dual_irq_bank dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .pin_in(pins),
        .pin_out(pin_out), .pin_drive(pin_drive), .irq_o(irq_o), .wake_o(wake_o)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'h00, 32'h0,        4'hF, 32'h18,       8'd1},  // R1 ident
        '{1'b0, 8'h14, 32'h0,        4'hF, 32'h1,        8'd1},  // R1 done
        '{1'b1, 8'h00, 32'hFFFFFFFF, 4'hF, 32'h0,        8'd1},  // R1 write ignored
        '{1'b0, 8'h00, 32'h0,        4'hF, 32'h18,       8'd1},
        '{1'b0, 8'h7C, 32'h0,        4'hF, 32'h0,        8'd1},  // R1 unmapped
        '{1'b0, 8'h34, 32'h0,        4'hF, 32'hFFFFFFFF, 8'd3},  // R3 reset values
        '{1'b0, 8'h30, 32'h0,        4'hF, 32'h2,        8'd3},
        '{1'b0, 8'h18, 32'h0,        4'hF, 32'h0,        8'd3},
        '{1'b0, 8'h28, 32'h0,        4'hF, 32'h0,        8'd3},
        '{1'b0, 8'h3C, 32'h0,        4'hF, 32'h0,        8'd3},
        '{1'b1, 8'h10, 32'hFD,       4'hF, 32'h0,        8'd2},  // R2 mask
        '{1'b0, 8'h10, 32'h0,        4'hF, 32'h1D,       8'd2},
        '{1'b1, 8'h10, 32'h0,        4'hF, 32'h0,        8'd2},
        '{1'b1, 8'h30, 32'hFF,       4'hF, 32'h0,        8'd14}, // R14 widths
        '{1'b0, 8'h30, 32'h0,        4'hF, 32'h7,        8'd14},
        '{1'b1, 8'h54, 32'hFFFF,     4'hF, 32'h0,        8'd14},
        '{1'b0, 8'h54, 32'h0,        4'hF, 32'hFF,       8'd14},
        '{1'b1, 8'h50, 32'hFFFFFFFF, 4'hF, 32'h0,        8'd12}, // R12 merge
        '{1'b1, 8'h50, 32'h0,        4'h2, 32'h0,        8'd12},
        '{1'b0, 8'h50, 32'h0,        4'hF, 32'hFFFF00FF, 8'd12},
        '{1'b1, 8'h64, 32'hFFFFFFFF, 4'h1, 32'h0,        8'd12}, // R12 alias lanes only
        '{1'b0, 8'h1C, 32'h0,        4'hF, 32'hFF,       8'd12},
        '{1'b1, 8'h60, 32'hF,        4'hF, 32'h0,        8'd9},  // R9 enable aliases
        '{1'b0, 8'h64, 32'h0,        4'hF, 32'hF0,       8'd9},
        '{1'b1, 8'h74, 32'hFF00,     4'hF, 32'h0,        8'd9},
        '{1'b0, 8'h70, 32'h0,        4'hF, 32'hFF00,     8'd9},
        '{1'b1, 8'h3C, 32'hF0F0,     4'hF, 32'h0,        8'd10}, // R10 data aliases
        '{1'b1, 8'h94, 32'hF,        4'hF, 32'h0,        8'd10},
        '{1'b0, 8'h3C, 32'h0,        4'hF, 32'hF0FF,     8'd10},
        '{1'b1, 8'h90, 32'hF0,       4'hF, 32'h0,        8'd10},
        '{1'b0, 8'h94, 32'h0,        4'hF, 32'hF00F,     8'd10},
        '{1'b1, 8'h84, 32'h11,       4'hF, 32'h0,        8'd11}, // R11 wake enable aliases
        '{1'b1, 8'h80, 32'h1,        4'hF, 32'h0,        8'd11},
        '{1'b0, 8'h20, 32'h0,        4'hF, 32'h10,       8'd11},
        '{1'b1, 8'h1C, 32'h0,        4'hF, 32'h0,        8'd9},
        '{1'b1, 8'h2C, 32'h0,        4'hF, 32'h0,        8'd9},
        '{1'b0, 8'h2C, 32'h0,        4'hF, 32'h0,        8'd9}
    };

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] addr, input logic [31:0] data, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] addr, output logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        #1 data = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_check(input int req, input string what, input logic [7:0] addr, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(addr, d);
        check(req, what, d, exp);
    endtask

    // pin change is visible in status two clocks later
    task automatic pin_set(input int idx, input logic v);
        @(negedge clk);
        pins[idx] = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3: outputs after reset
        check(3, "drive after reset", pin_drive, 32'h0);
        check(3, "irq after reset", {30'b0, irq_o}, 32'h0);
        check(3, "wake after reset", {31'b0, wake_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr)
                bus_write(TBL[i].addr, TBL[i].data, TBL[i].be);
            else
                read_check(int'(TBL[i].req), $sformatf("table step %0d", i), TBL[i].addr, TBL[i].exp);
        end

        // R10: direction controls the drivers, data reaches pins
        bus_write(8'h34, 32'hFFFF0000, 4'hF);
        @(negedge clk);
        check(10, "pin_drive", pin_drive, 32'h0000FFFF);
        check(10, "pin_out", pin_out & 32'hFFFF, 32'hF00F);
        bus_write(8'h34, 32'hFFFFFFFF, 4'hF);

        // R4: rising edge sets both banks, R14 pin read
        bus_write(8'h48, 32'h1, 4'hF);
        bus_write(8'h4C, 32'h2, 4'hF);
        pin_set(0, 1'b1);
        read_check(4, "rise bank0", 8'h18, 32'h1);
        read_check(4, "rise bank1", 8'h28, 32'h1);
        read_check(14, "pin level read", 8'h38, 32'h1);
        pin_set(1, 1'b1);
        read_check(4, "rise on fall-only line", 8'h18, 32'h1);
        pin_set(1, 1'b0);
        read_check(4, "fall bank0", 8'h18, 32'h3);
        bus_write(8'h18, 32'hFFFFFFFF, 4'hF);
        bus_write(8'h28, 32'hFFFFFFFF, 4'hF);
        read_check(6, "clear without level", 8'h18, 32'h0);

        // R8: interrupt follows status AND enable
        bus_write(8'h1C, 32'h1, 4'hF);
        @(negedge clk);
        check(8, "irq idle", {30'b0, irq_o}, 32'h0);
        pin_set(0, 1'b0);
        pin_set(0, 1'b1);
        check(8, "irq bank0 high, bank1 disabled", {30'b0, irq_o}, 32'h1);
        bus_write(8'h18, 32'h1, 4'hF);
        @(negedge clk);
        check(8, "irq after clear", {30'b0, irq_o}, 32'h0);
        bus_write(8'h28, 32'hFFFFFFFF, 4'hF);

        // R5, R6: level high still present re-sets after clear
        bus_write(8'h44, 32'h8, 4'hF);
        pin_set(3, 1'b1);
        read_check(5, "level high event", 8'h18, 32'h8);
        bus_write(8'h18, 32'h8, 4'hF);
        read_check(6, "level re-set after clear", 8'h18, 32'h8);
        pin_set(3, 1'b0);
        bus_write(8'h18, 32'h8, 4'hF);
        read_check(6, "clear after level gone", 8'h18, 32'h0);
        read_check(6, "bank1 untouched by bank0 clear", 8'h28, 32'h8);

        // R7: level-low register write re-evaluates both banks
        bus_write(8'h28, 32'hFFFFFFFF, 4'hF);
        bus_write(8'h40, 32'h10, 4'hF);
        read_check(7, "level-low write bank0", 8'h18, 32'h10);
        read_check(7, "level-low write bank1", 8'h28, 32'h10);
        bus_write(8'h40, 32'h0, 4'hF);
        bus_write(8'h18, 32'hFFFFFFFF, 4'hF);
        bus_write(8'h28, 32'hFFFFFFFF, 4'hF);

        // R7: output line ignored, then direction write picks it up
        bus_write(8'h34, 32'hFFFFFFDF, 4'hF);
        bus_write(8'h44, 32'h28, 4'hF);
        pin_set(5, 1'b1);
        bus_write(8'h18, 32'hFFFFFFFF, 4'hF);
        read_check(4, "output line no event", 8'h18, 32'h0);
        bus_write(8'h34, 32'hFFFFFFFF, 4'hF);
        read_check(7, "direction write bank0", 8'h18, 32'h20);
        read_check(7, "direction write bank1", 8'h28, 32'h20);
        bus_write(8'h44, 32'h0, 4'hF);
        pin_set(5, 1'b0);
        bus_write(8'h18, 32'hFFFFFFFF, 4'hF);
        bus_write(8'h28, 32'hFFFFFFFF, 4'hF);

        // R11: wakeup gating (wake enable holds bit 4 only)
        bus_write(8'h48, 32'h11, 4'hF);
        pin_set(4, 1'b1);
        check(11, "wake with config 0", {31'b0, wake_o}, 32'h0);
        pin_set(4, 1'b0);
        bus_write(8'h10, 32'h04, 4'hF);
        pin_set(4, 1'b1);
        check(11, "wake with idle mode 0", {31'b0, wake_o}, 32'h0);
        pin_set(4, 1'b0);
        bus_write(8'h10, 32'h0C, 4'hF);
        pin_set(4, 1'b1);
        check(11, "wake fully enabled", {31'b0, wake_o}, 32'h1);
        @(negedge clk);
        check(11, "wake one cycle", {31'b0, wake_o}, 32'h0);
        pin_set(0, 1'b0);
        pin_set(0, 1'b1);
        check(11, "wake on line not enabled", {31'b0, wake_o}, 32'h0);

        // R13: clear and event on the same bit in the same cycle
        pin_set(0, 1'b0);
        bus_write(8'h18, 32'hFFFFFFFF, 4'hF);
        bus_write(8'h28, 32'hFFFFFFFF, 4'hF);
        @(negedge clk);
        pins[0] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h1; bus_be = 4'hF;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        read_check(13, "event beats clear", 8'h18, 32'h1);

        // R2: soft reset
        bus_write(8'h3C, 32'h1234, 4'hF);
        bus_write(8'h34, 32'h0, 4'hF);
        bus_write(8'h10, 32'h02, 4'hF);
        read_check(2, "soft reset data", 8'h3C, 32'h0);
        read_check(2, "soft reset direction", 8'h34, 32'hFFFFFFFF);
        read_check(2, "soft reset control", 8'h30, 32'h2);
        read_check(2, "soft reset config", 8'h10, 32'h0);
        read_check(2, "soft reset status", 8'h18, 32'h0);
        read_check(2, "soft reset wake enable", 8'h20, 32'h0);

        done = 1;
        report();
        $finish;
    end
endmodule